// File: doc/BRIEF.md
# Register-Programmed SPI Command Engine

This block is a host-side SPI master controlled through eight byte-wide registers. Firmware first stores an opcode, up to three address bytes and one extra data byte in their registers. It then writes a control byte that selects the clock rate, the number of response bytes and the command length. The engine frames the transfer with chip select and shifts the command out most significant bit first in SPI mode 0. Response bytes are captured into registers, and a busy flag in the control register tells firmware when the result can be read.

Command lengths are limited to 1, 2, 4 or 5 bytes, opcode included, and up to three bytes can be read back. The address registers are stored in the opposite order to the wire order, and the trailing data byte has its own register. The same register also holds the last response byte of a three-byte read. Two serial clock rates come from one system clock, each set by a half-period parameter.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset, chip select is high, the serial clock and data-out are low, busy is clear and all eight offsets read as zero.
- R2: A write to offset 0 starts a transfer only when the engine is idle and the upper nibble of the written byte is 4 or 5. Any other control write leaves the offset 0 readback and the serial pins unchanged.
- R3: The opcode at offset 1 is sent first, MSB first. The command length is set by control bits [1:0]: code 0 sends the opcode alone; code 1 adds offset 7; code 2 adds offsets 4, 3, 2 in that order; code 3 adds offsets 4, 3, 2 and then 7. Data-out is low while response bytes are clocked.
- R4: Control bits [3:2] give the response count (0 to 3). Data-in is sampled on each rising serial clock. After the transfer, the response bytes appear at offsets 5, 6, 7 in the order received, and offsets above the count keep their previous contents.
- R5: SPI mode 0 is used. The serial clock idles low, every bit has a low half followed by a high half, and data-out changes only while the serial clock is low.
- R6: Chip select falls on the cycle after the accepted control write. It stays low through the high half of the final bit and rises together with the final falling clock edge.
- R7: Control upper nibble 5 selects a half-period of FAST_HALF system clocks, and 4 selects SLOW_HALF system clocks.
- R8: Bit 7 of offset 0 reads 1 from the cycle after the start until one cycle after chip select rises.
- R9: Writes to any offset while busy are ignored, and a control write made while busy starts no transfer.
- R10: When idle, offset 0 reads back bits [6:0] of the last accepted control byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register offset for read and write |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for reg_addr_i (combinational) |
| spi_sck_o | output | 1 | Serial clock |
| spi_cs_n_o | output | 1 | Active-low chip select |
| spi_mosi_o | output | 1 | Serial data out |
| spi_miso_i | input | 1 | Serial data in |

## Verification
The bench predicts the value of chip select, serial clock, data-out and busy for every system clock, so any fault in the divider, bit counter or state sequencing shows as a pin mismatch within one cycle. A wrong bit count or length decode first shows at the cycle where chip select should rise, or where an extra clock pulse appears. A shift register loaded or advanced out of order shows on data-out at the first wrong bit. Faults in response capture or write blocking stay hidden until the offsets are read back after the transfer, and the bench performs those reads immediately.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

    localparam int BYTE_W       = 8;
    localparam int REG_CNT      = 8;
    localparam int ADDR_W       = $clog2(REG_CNT);
    localparam int MAX_WR_BYTES = 5;
    localparam int MAX_RD_BYTES = 3;
    localparam int FRAME_W      = BYTE_W * MAX_WR_BYTES;
    localparam int RESP_W       = BYTE_W * MAX_RD_BYTES;
    localparam int CNT_W        = $clog2(MAX_WR_BYTES + 1);

    // register offsets whose position the sequencing depends on
    localparam int OFS_CTRL   = 0;
    localparam int OFS_OP     = 1;
    localparam int OFS_ADR_LO = 2;
    localparam int OFS_ADR_MD = 3;
    localparam int OFS_ADR_HI = 4;
    localparam int OFS_RESP0  = 5;
    localparam int OFS_EXTRA  = 7;

    localparam logic [3:0] RATE_SLOW = 4'h4;
    localparam logic [3:0] RATE_FAST = 4'h5;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_SHIFT,
        SEQ_DONE
    } seq_state_t;

    // total bytes on the wire for a length code
    function automatic logic [CNT_W-1:0] len_bytes(input logic [1:0] code);
        case (code)
            2'd0:    len_bytes = CNT_W'(1);
            2'd1:    len_bytes = CNT_W'(2);
            2'd2:    len_bytes = CNT_W'(4);
            default: len_bytes = CNT_W'(5);
        endcase
    endfunction

endpackage

// File: rtl/spi_cmd_regs.sv
module spi_cmd_regs
    import spi_cmd_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en_i,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic [BYTE_W-1:0]    wdata_i,
    input  logic                 busy_i,
    input  logic                 done_i,
    input  logic [RESP_W-1:0]    resp_i,
    output logic [BYTE_W-1:0]    rdata_o,
    output logic                 start_o,
    output logic                 fast_o,
    output logic [1:0]           rcnt_o,
    output logic [CNT_W-1:0]     nbytes_o,
    output logic [FRAME_W-1:0]   frame_o
);

    typedef struct packed {
        logic [REG_CNT-1:0][BYTE_W-1:0] r;
    } regs_t;

    regs_t q, d;
    logic  rate_ok;
    int    rc;

    assign rate_ok = (wdata_i[7:4] == RATE_SLOW) || (wdata_i[7:4] == RATE_FAST);

    always_comb begin
        d       = q;
        start_o = 1'b0;
        rc      = int'(q.r[OFS_CTRL][3:2]);
        if (wr_en_i && !busy_i) begin
            if (addr_i == ADDR_W'(OFS_CTRL)) begin
                if (rate_ok) begin
                    d.r[OFS_CTRL] = wdata_i;
                    start_o       = 1'b1;
                end
            end else begin
                d.r[addr_i] = wdata_i;
            end
        end
        if (done_i) begin
            for (int j = 0; j < MAX_RD_BYTES; j++) begin
                if (j < rc) begin
                    d.r[OFS_RESP0 + j] = resp_i[BYTE_W*(rc-1-j) +: BYTE_W];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // command framing: opcode, then address high to low, then extra byte
    always_comb begin
        case (wdata_i[1:0])
            2'd0: frame_o = {q.r[OFS_OP], {(4*BYTE_W){1'b0}}};
            2'd1: frame_o = {q.r[OFS_OP], q.r[OFS_EXTRA], {(3*BYTE_W){1'b0}}};
            2'd2: frame_o = {q.r[OFS_OP], q.r[OFS_ADR_HI], q.r[OFS_ADR_MD],
                             q.r[OFS_ADR_LO], {BYTE_W{1'b0}}};
            default: frame_o = {q.r[OFS_OP], q.r[OFS_ADR_HI], q.r[OFS_ADR_MD],
                                q.r[OFS_ADR_LO], q.r[OFS_EXTRA]};
        endcase
    end

    assign fast_o   = (wdata_i[7:4] == RATE_FAST);
    assign rcnt_o   = wdata_i[3:2];
    assign nbytes_o = len_bytes(wdata_i[1:0]);
    assign rdata_o  = (addr_i == ADDR_W'(OFS_CTRL)) ? {busy_i, q.r[OFS_CTRL][6:0]}
                                                    : q.r[addr_i];

    // R9
    opcode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy_i) |-> $stable(q.r[OFS_OP]));

    // R2
    ctrl_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == ADDR_W'(OFS_CTRL) && !start_o) |=> $stable(q.r[OFS_CTRL]));

endmodule

// File: rtl/spi_cmd_seq.sv
module spi_cmd_seq
    import spi_cmd_pkg::*;
#(
    parameter int FAST_HALF = 1,
    parameter int SLOW_HALF = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               fast_i,
    input  logic [1:0]         rcnt_i,
    input  logic [CNT_W-1:0]   nbytes_i,
    input  logic [FRAME_W-1:0] frame_i,
    input  logic               miso_i,
    output logic               sck_o,
    output logic               cs_n_o,
    output logic               mosi_o,
    output logic               busy_o,
    output logic               done_o,
    output logic [RESP_W-1:0]  resp_o
);

    localparam int HALF_MAX = (FAST_HALF > SLOW_HALF) ? FAST_HALF : SLOW_HALF;
    localparam int DIV_W    = $clog2(HALF_MAX + 1);
    localparam int BITS_MAX = BYTE_W * (MAX_WR_BYTES + MAX_RD_BYTES);
    localparam int BIT_W    = $clog2(BITS_MAX);

    typedef struct packed {
        seq_state_t         state;
        logic [DIV_W-1:0]   div;
        logic [DIV_W-1:0]   div_end;
        logic               high;
        logic [BIT_W-1:0]   bitcnt;
        logic [BIT_W-1:0]   bit_end;
        logic [FRAME_W-1:0] tx;
        logic [RESP_W-1:0]  rx;
        logic               sck;
        logic               cs_n;
        logic               done;
    } seq_t;

    seq_t q, d;
    int   total_bits;

    always_comb begin
        d          = q;
        d.done     = 1'b0;
        total_bits = BYTE_W * (int'(nbytes_i) + int'(rcnt_i));
        case (q.state)
            SEQ_IDLE: begin
                if (start_i) begin
                    d.state   = SEQ_SHIFT;
                    d.div     = '0;
                    d.div_end = fast_i ? DIV_W'(FAST_HALF - 1) : DIV_W'(SLOW_HALF - 1);
                    d.high    = 1'b0;
                    d.bitcnt  = '0;
                    d.bit_end = BIT_W'(total_bits - 1);
                    d.tx      = frame_i;
                    d.rx      = '0;
                    d.sck     = 1'b0;
                    d.cs_n    = 1'b0;
                end
            end
            SEQ_SHIFT: begin
                if (q.div == q.div_end) begin
                    d.div = '0;
                    if (!q.high) begin
                        d.high = 1'b1;
                        d.sck  = 1'b1;
                        d.rx   = {q.rx[RESP_W-2:0], miso_i};
                    end else begin
                        d.high = 1'b0;
                        d.sck  = 1'b0;
                        if (q.bitcnt == q.bit_end) begin
                            d.state = SEQ_DONE;
                            d.cs_n  = 1'b1;
                            d.done  = 1'b1;
                        end else begin
                            d.bitcnt = q.bitcnt + 1'b1;
                            d.tx     = {q.tx[FRAME_W-2:0], 1'b0};
                        end
                    end
                end else begin
                    d.div = q.div + 1'b1;
                end
            end
            default: d.state = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.cs_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign sck_o  = q.sck;
    assign cs_n_o = q.cs_n;
    assign mosi_o = (q.state == SEQ_SHIFT) && q.tx[FRAME_W-1];
    assign busy_o = (q.state != SEQ_IDLE);
    assign done_o = q.done;
    assign resp_o = q.rx;

    // R5
    sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> !sck_o);

    // R5
    mosi_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sck_o && !cs_n_o) |-> $stable(mosi_o));

    // R6
    start_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (!cs_n_o && busy_o));

    // R8
    busy_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n_o) |-> busy_o);

    // R8
    busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n_o) |=> !busy_o);

endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
    import spi_cmd_pkg::*;
#(
    parameter int FAST_HALF = 1,
    parameter int SLOW_HALF = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr_i,
    input  logic [2:0] reg_addr_i,
    input  logic [7:0] reg_wdata_i,
    output logic [7:0] reg_rdata_o,
    output logic       spi_sck_o,
    output logic       spi_cs_n_o,
    output logic       spi_mosi_o,
    input  logic       spi_miso_i
);

    logic               start, fast, busy, done;
    logic [1:0]         rcnt;
    logic [CNT_W-1:0]   nbytes;
    logic [FRAME_W-1:0] frame;
    logic [RESP_W-1:0]  resp;

    spi_cmd_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en_i  (reg_wr_i),
        .addr_i   (reg_addr_i),
        .wdata_i  (reg_wdata_i),
        .busy_i   (busy),
        .done_i   (done),
        .resp_i   (resp),
        .rdata_o  (reg_rdata_o),
        .start_o  (start),
        .fast_o   (fast),
        .rcnt_o   (rcnt),
        .nbytes_o (nbytes),
        .frame_o  (frame)
    );

    spi_cmd_seq #(
        .FAST_HALF (FAST_HALF),
        .SLOW_HALF (SLOW_HALF)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start),
        .fast_i   (fast),
        .rcnt_i   (rcnt),
        .nbytes_i (nbytes),
        .frame_i  (frame),
        .miso_i   (spi_miso_i),
        .sck_o    (spi_sck_o),
        .cs_n_o   (spi_cs_n_o),
        .mosi_o   (spi_mosi_o),
        .busy_o   (busy),
        .done_o   (done),
        .resp_o   (resp)
    );

endmodule

// File: tb/tb_spi_cmd_engine.sv
module tb_spi_cmd_engine;

    localparam int FH = 1;
    localparam int SH = 2;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr;
    logic [2:0] addr;
    logic [7:0] wdata, rdata;
    logic       sck, cs_n, mosi, miso;

    always #10 clk = ~clk;

    spi_cmd_engine #(.FAST_HALF(FH), .SLOW_HALF(SH)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr_i(wr), .reg_addr_i(addr),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata), .spi_sck_o(sck),
        .spi_cs_n_o(cs_n), .spi_mosi_o(mosi), .spi_miso_i(miso)
    );

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    // expected pins per cycle: {busy, cs_n, sck, mosi}
    logic [3:0] expq[$];
    logic [3:0] cur = 4'b0100;
    logic [7:0] mem [8];
    logic [7:0] pend [3];
    int         pend_n = 0;
    logic [63:0] pat;
    int          rises = 0;

    // slave: next bit presented after each rising clock
    always @(posedge sck or negedge cs_n) begin
        if (sck) rises = rises + 1;
        else     rises = 0;
        if (rises < 64) miso = pat[63-rises];
    end

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    task automatic plan_transfer(input logic [7:0] c);
        logic [7:0] w[$];
        int h, nb, rc, n;
        logic bv;
        w.push_back(mem[1]);
        case (c[1:0])
            2'd1: w.push_back(mem[7]);
            2'd2: begin w.push_back(mem[4]); w.push_back(mem[3]); w.push_back(mem[2]); end
            2'd3: begin w.push_back(mem[4]); w.push_back(mem[3]); w.push_back(mem[2]);
                        w.push_back(mem[7]); end
            default: ;
        endcase
        h  = c[4] ? FH : SH;
        nb = w.size();
        rc = int'(c[3:2]);
        n  = 8 * (nb + rc);
        for (int b = 0; b < n; b++) begin
            bv = (b < 8*nb) ? w[b/8][7-(b%8)] : 1'b0;
            for (int k = 0; k < h; k++) expq.push_back({1'b1, 1'b0, 1'b0, bv});
            for (int k = 0; k < h; k++) expq.push_back({1'b1, 1'b0, 1'b1, bv});
        end
        expq.push_back(4'b1100);
        for (int j = 0; j < rc; j++)
            for (int k = 0; k < 8; k++)
                pend[j][7-k] = pat[63-(n - 8*rc + 8*j + k)];
        pend_n = rc;
    endtask

    // reference model reacts to register writes at the clock edge
    always @(posedge clk) begin
        if (rst_n && wr && !cur[3]) begin
            if (addr == 3'd0) begin
                if (wdata[7:4] == 4'h4 || wdata[7:4] == 4'h5) begin
                    mem[0] = wdata;
                    plan_transfer(wdata);
                end
            end else begin
                mem[addr] = wdata;
            end
        end
    end

    // per-cycle pin comparison
    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            cur = (expq.size() > 0) ? expq.pop_front() : 4'b0100;
            if (cur == 4'b1100)
                for (int j = 0; j < pend_n; j++) mem[5+j] = pend[j];
            checks++;
            if (cs_n !== cur[2]) begin
                errors++;
                $display("FAIL R6 cs_n cycle %0d: got %b expected %b", cyc, cs_n, cur[2]);
            end
            if (sck !== cur[1]) begin
                errors++;
                $display("FAIL R5 R7 sck cycle %0d: got %b expected %b", cyc, sck, cur[1]);
            end
            if (mosi !== cur[0]) begin
                errors++;
                $display("FAIL R3 mosi cycle %0d: got %b expected %b", cyc, mosi, cur[0]);
            end
            if (dut.reg_rdata_o[7] !== cur[3] && addr == 3'd0) begin
                errors++;
                $display("FAIL R8 busy cycle %0d: got %b expected %b", cyc, rdata[7], cur[3]);
            end
            if (cyc > 100000) begin
                errors++;
                $display("FAIL R8 watchdog expired: got running expected idle");
                summary();
                $finish;
            end
        end
    end

    task automatic wr_reg(input int a, input logic [7:0] v);
        @(negedge clk); #2;
        wr = 1'b1; addr = 3'(a); wdata = v;
        @(negedge clk); #2;
        wr = 1'b0; addr = 3'd0;
    endtask

    task automatic rd_chk(input int a, input logic [7:0] exp, input string tag);
        @(negedge clk); #2;
        addr = 3'(a);
        #1;
        checks++;
        if (rdata !== exp) begin
            errors++;
            $display("FAIL %s offset %0d: got %h expected %h", tag, a, rdata, exp);
        end
        addr = 3'd0;
    endtask

    task automatic wait_idle();
        @(negedge clk); #3;
        while (expq.size() != 0 || cur[3]) begin
            @(negedge clk); #3;
        end
    endtask

    initial begin
        for (int i = 0; i < 8; i++) mem[i] = 8'h00;
        pat   = 64'hC3A5_5A3C_9617_E248;
        miso  = pat[63];
        wr    = 1'b0;
        addr  = 3'd0;
        wdata = 8'h00;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        checks++;
        if (cs_n !== 1'b1 || sck !== 1'b0 || mosi !== 1'b0) begin
            errors++;
            $display("FAIL R1 pins in reset: got %b%b%b expected 100", cs_n, sck, mosi);
        end
        rst_n = 1'b1;
        for (int i = 0; i < 8; i++) rd_chk(i, 8'h00, "R1");

        // R4 R7: opcode alone, three response bytes, fast rate
        wr_reg(1, 8'h9F);
        wr_reg(0, 8'h5C);
        wait_idle();
        rd_chk(5, mem[5], "R4");
        rd_chk(6, mem[6], "R4");
        rd_chk(7, mem[7], "R4");
        rd_chk(0, 8'h5C, "R10");

        // R3 R7: five-byte command, slow rate, no response
        wr_reg(2, 8'h33);
        wr_reg(3, 8'h22);
        wr_reg(4, 8'h11);
        wr_reg(7, 8'hAB);
        wr_reg(1, 8'h02);
        wr_reg(0, 8'h43);
        wait_idle();
        rd_chk(0, 8'h43, "R10");
        rd_chk(7, 8'hAB, "R4");

        // R3 R4: four-byte command with one response byte
        pat = 64'h5E00_0000_0000_1234;
        wr_reg(1, 8'h03);
        wr_reg(0, 8'h46);
        wait_idle();
        rd_chk(5, mem[5], "R4");
        rd_chk(6, mem[6], "R4");
        rd_chk(7, 8'hAB, "R4");

        // R3 R4: two-byte command with two response bytes, fast
        pat = 64'h0F0F_F0F0_1357_9BDF;
        wr_reg(1, 8'h01);
        wr_reg(7, 8'h6D);
        wr_reg(0, 8'h59);
        wait_idle();
        rd_chk(5, mem[5], "R4");
        rd_chk(6, mem[6], "R4");
        rd_chk(7, 8'h6D, "R3");

        // R2: rejected control nibbles
        wr_reg(0, 8'h6C);
        wr_reg(0, 8'h00);
        wr_reg(0, 8'h1F);
        repeat (4) @(negedge clk);
        rd_chk(0, 8'h59, "R2");

        // R9: writes while busy
        wr_reg(1, 8'hC7);
        wr_reg(0, 8'h40);
        wr_reg(1, 8'hEE);
        wr_reg(4, 8'h77);
        wr_reg(0, 8'h5F);
        wait_idle();
        rd_chk(1, 8'hC7, "R9");
        rd_chk(4, 8'h11, "R9");
        rd_chk(0, 8'h40, "R9");

        // R6 R8: back-to-back start right after busy clears
        wr_reg(0, 8'h50);
        wait_idle();
        wr_reg(0, 8'h44);
        wait_idle();
        rd_chk(0, 8'h44, "R10");
        rd_chk(5, mem[5], "R4");

        repeat (4) @(negedge clk);
        summary();
        $finish;
    end

endmodule